// File: doc/BRIEF.md
# Cross-Bank Gate After Auto-Precharge Access

This block sits beside a DRAM command scheduler. It remembers the last READ or WRITE that was issued with auto precharge, and in every cycle it says which kinds of command may go to a bank other than that one. While the earlier burst is still moving data, a command to another bank must wait. How long it waits depends on the direction of the earlier access, the direction of the new one, the burst length, the rounded-up CAS latency and the write-to-read turnaround time.

The block gives one allowed flag per command type. A command issued while its flag is low produces a one-cycle violation pulse. Auto refresh and mode-register loading are not timed here: they depend only on an all-banks-idle qualifier that the scheduler supplies. Commands to the bank that holds the tracked access are outside the scope of this gate and are never flagged. The configuration inputs are read at the moment an auto-precharge access is accepted.

Top module: `ap_xbank_gate`

## Requirements
- R1: After reset, `allow_rd`, `allow_wr`, `allow_pre` and `allow_act` are high and `violation` is low. Command codes on `cmd_op`: 0 none, 1 activate, 2 read, 3 read with auto precharge, 4 write, 5 write with auto precharge, 6 precharge, 7 auto refresh, 8 mode-register load. Codes 9 to 15 act as no command.
- R2: Suppose a write with auto precharge is accepted in cycle t. A read to another bank is then allowed from cycle t + 1 + BL/2 + tWTR. tWTR is the `cfg_twtr` value, in cycles.
- R3: After a write with auto precharge is accepted in cycle t, a write to another bank is allowed from cycle t + BL/2.
- R4: After a read with auto precharge is accepted in cycle t, a read to another bank is allowed from cycle t + BL/2.
- R5: After a read with auto precharge is accepted in cycle t, a write to another bank is allowed from cycle t + CLup + BL/2. CLup is `cfg_cl_int` + `cfg_cl_half`. The half bit marks a CAS latency of int + 0.5, which is rounded up.
- R6: After either kind of auto-precharge access, a precharge or activate to another bank is allowed one cycle later. As a result, `allow_pre` and `allow_act` are never low outside reset.
- R7: `allow_ref` and `allow_lmr` follow `all_banks_idle`. A refresh or mode-register load issued while that qualifier is low is a violation.
- R8: A command to a bank other than the tracked one, issued while the flag for its type is low, makes `violation` high in the next cycle only. Any other command leaves `violation` low in the next cycle.
- R9: A violating command changes neither the timing state nor the tracked bank. This holds even when the violating command is itself an auto-precharge access.
- R10: A command to the tracked bank is never a violation. An auto-precharge access to that bank is accepted and restarts the timing.
- R11: BL/2 equals 1 << `cfg_bl_code` (code 0..3 gives BL 2, 4, 8 or 16). Every accepted auto-precharge access restarts all windows with its own delays. A configuration change after acceptance does not alter a window that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 4 | Command code (see R1) |
| cmd_bank | input | BANK_W | Target bank of the command |
| cfg_bl_code | input | 2 | Burst length code, BL/2 = 1 << code |
| cfg_cl_int | input | CL_W | Integer part of CAS latency |
| cfg_cl_half | input | 1 | CAS latency has an extra half cycle |
| cfg_twtr | input | TWTR_W | Write-to-read turnaround, cycles |
| all_banks_idle | input | 1 | Every bank is precharged and idle |
| allow_rd | output | 1 | Read to another bank allowed this cycle |
| allow_wr | output | 1 | Write to another bank allowed this cycle |
| allow_pre | output | 1 | Precharge to another bank allowed |
| allow_act | output | 1 | Activate to another bank allowed |
| allow_ref | output | 1 | Auto refresh allowed |
| allow_lmr | output | 1 | Mode-register load allowed |
| violation | output | 1 | Previous cycle's command broke a rule |

## Verification
The checker follows the tracked bank itself. On every cycle it checks the following: flags drop right after an accepted auto-precharge access; an illegal read or refresh to another bank is followed by a violation pulse; the pulse never appears without a preceding command; same-bank commands never raise it; and a violating auto-precharge access leaves an open read window open. The exact length of each window can only be shown by the bench's scenarios. So can the rounding of a half-cycle CAS latency, the BL/2 = 8 setting, and the rule that a configuration change during a running window has no effect. The bench measures these against delays it computes from the requirements.

// File: rtl/ap_xbank_pkg.sv
package ap_xbank_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_ACT   = 4'd1,
        OP_RD    = 4'd2,
        OP_RDAP  = 4'd3,
        OP_WR    = 4'd4,
        OP_WRAP  = 4'd5,
        OP_PRE   = 4'd6,
        OP_REF   = 4'd7,
        OP_LMR   = 4'd8
    } op_e;

    // Target classes: each has its own window counter.
    typedef enum logic [1:0] {
        TGT_RD   = 2'd0,
        TGT_WR   = 2'd1,
        TGT_PA   = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    localparam int NUM_TGT = 3;

    typedef struct packed {
        tgt_e tgt;        // window that governs this command
        logic is_ap;      // access with auto precharge
        logic src_wr;     // auto-precharge access is a write
        logic needs_idle; // refresh or mode-register load
    } cmd_info_t;

    function automatic int half_burst(input int code);
        return 1 << code;
    endfunction

    function automatic int cas_rounded(input int whole, input logic half);
        return whole + (half ? 1 : 0);
    endfunction

    // Minimum distance in cycles from an auto-precharge access to a
    // command of the given class on another bank.
    function automatic int min_gap(input logic src_wr, input tgt_e tgt,
                                   input int hb, input int cl_up, input int twtr);
        int gap;
        case (tgt)
            TGT_RD:  gap = src_wr ? (1 + hb + twtr) : hb;
            TGT_WR:  gap = src_wr ? hb : (cl_up + hb);
            default: gap = 1;
        endcase
        return gap;
    endfunction

endpackage

// File: rtl/ap_xbank_decode.sv
module ap_xbank_decode
    import ap_xbank_pkg::*;
(
    input  logic [3:0] op_raw,
    output cmd_info_t  info
);
    always_comb begin
        info.tgt        = TGT_NONE;
        info.is_ap      = 1'b0;
        info.src_wr     = 1'b0;
        info.needs_idle = 1'b0;
        case (op_e'(op_raw))
            OP_RD:   info.tgt = TGT_RD;
            OP_RDAP: begin
                info.tgt   = TGT_RD;
                info.is_ap = 1'b1;
            end
            OP_WR:   info.tgt = TGT_WR;
            OP_WRAP: begin
                info.tgt    = TGT_WR;
                info.is_ap  = 1'b1;
                info.src_wr = 1'b1;
            end
            OP_ACT, OP_PRE: info.tgt = TGT_PA;
            OP_REF, OP_LMR: info.needs_idle = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ap_xbank_delay.sv
module ap_xbank_delay
    import ap_xbank_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int CL_W   = 3,
    parameter int TWTR_W = 4,
    parameter int BLC_W  = 2
) (
    input  logic                              src_wr,
    input  logic [BLC_W-1:0]                  bl_code,
    input  logic [CL_W-1:0]                   cl_int,
    input  logic                              cl_half,
    input  logic [TWTR_W-1:0]                 twtr,
    output logic [NUM_TGT-1:0][CNT_W-1:0]     load_val
);
    int hb;
    int cl_up;

    always_comb begin
        hb    = half_burst(int'(bl_code));
        cl_up = cas_rounded(int'(cl_int), cl_half);
    end

    // Counter is loaded with gap-1 so that it reads zero in cycle t+gap.
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_gap
        always_comb begin
            load_val[g] = CNT_W'(min_gap(src_wr, tgt_e'(g), hb, cl_up, int'(twtr)) - 1);
        end
    end
endmodule

// File: rtl/ap_xbank_counter.sv
module ap_xbank_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - W'(1);
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/ap_xbank_gate.sv
module ap_xbank_gate
    import ap_xbank_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int CL_W   = 3,
    parameter int TWTR_W = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [1:0]        cfg_bl_code,
    input  logic [CL_W-1:0]   cfg_cl_int,
    input  logic              cfg_cl_half,
    input  logic [TWTR_W-1:0] cfg_twtr,
    input  logic              all_banks_idle,
    output logic              allow_rd,
    output logic              allow_wr,
    output logic              allow_pre,
    output logic              allow_act,
    output logic              allow_ref,
    output logic              allow_lmr,
    output logic              violation
);
    localparam int BLC_W = 2;

    cmd_info_t                      info;
    logic [NUM_TGT-1:0][CNT_W-1:0]  gap_val;
    logic [NUM_TGT-1:0]             open_vec;
    logic [BANK_W-1:0]              held_bank;
    logic                           other_bank;
    logic                           class_open;
    logic                           illegal;
    logic                           take_ap;
    logic                           viol_q;

    ap_xbank_decode u_decode (
        .op_raw (cmd_op),
        .info   (info)
    );

    ap_xbank_delay #(
        .CNT_W  (CNT_W),
        .CL_W   (CL_W),
        .TWTR_W (TWTR_W),
        .BLC_W  (BLC_W)
    ) u_delay (
        .src_wr   (info.src_wr),
        .bl_code  (cfg_bl_code),
        .cl_int   (cfg_cl_int),
        .cl_half  (cfg_cl_half),
        .twtr     (cfg_twtr),
        .load_val (gap_val)
    );

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_win
        ap_xbank_counter #(.W(CNT_W)) u_win (
            .clk      (clk),
            .rst      (rst),
            .load     (take_ap),
            .load_val (gap_val[g]),
            .expired  (open_vec[g])
        );
    end

    always_comb begin
        case (info.tgt)
            TGT_RD:  class_open = open_vec[0];
            TGT_WR:  class_open = open_vec[1];
            TGT_PA:  class_open = open_vec[2];
            default: class_open = 1'b1;
        endcase
    end

    always_comb begin
        other_bank = (cmd_bank != held_bank);
        illegal    = 1'b0;
        if (cmd_valid) begin
            if (info.needs_idle) begin
                illegal = !all_banks_idle;
            end else if (info.tgt != TGT_NONE) begin
                illegal = other_bank && !class_open;
            end
        end
        take_ap = cmd_valid && info.is_ap && !illegal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_bank <= '0;
            viol_q    <= 1'b0;
        end else begin
            viol_q <= illegal;
            if (take_ap) begin
                held_bank <= cmd_bank;
            end
        end
    end

    assign allow_rd  = open_vec[0];
    assign allow_wr  = open_vec[1];
    assign allow_pre = open_vec[2];
    assign allow_act = open_vec[2];
    assign allow_ref = all_banks_idle;
    assign allow_lmr = all_banks_idle;
    assign violation = viol_q;
endmodule

// File: rtl/ap_xbank_gate_chk.sv
module ap_xbank_gate_chk #(
    parameter int BANK_W = 2,
    parameter int CL_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [1:0]        cfg_bl_code,
    input logic [CL_W-1:0]   cfg_cl_int,
    input logic              cfg_cl_half,
    input logic              allow_rd,
    input logic              allow_wr,
    input logic              allow_pre,
    input logic              allow_act,
    input logic              allow_ref,
    input logic              allow_lmr,
    input logic              violation
);
    logic [BANK_W-1:0] shadow_bank;
    logic is_rd, is_wr, is_pa, rd_ap, wr_ap, same, acc_rd_ap, acc_wr_ap;

    always_comb begin
        is_rd     = cmd_valid && (cmd_op == 4'd2 || cmd_op == 4'd3);
        is_wr     = cmd_valid && (cmd_op == 4'd4 || cmd_op == 4'd5);
        is_pa     = cmd_valid && (cmd_op == 4'd1 || cmd_op == 4'd6);
        rd_ap     = cmd_valid && cmd_op == 4'd3;
        wr_ap     = cmd_valid && cmd_op == 4'd5;
        same      = (cmd_bank == shadow_bank);
        acc_rd_ap = rd_ap && (allow_rd || same);
        acc_wr_ap = wr_ap && (allow_wr || same);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_bank <= '0;
        end else if (acc_rd_ap || acc_wr_ap) begin
            shadow_bank <= cmd_bank;
        end
    end

    assert_wrap_closes_rd_R2: assert property (@(posedge clk) disable iff (rst)
        acc_wr_ap |=> !allow_rd);

    assert_wrap_closes_wr_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_wr_ap && cfg_bl_code != 2'd0) |=> !allow_wr);

    assert_rdap_closes_rd_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_rd_ap && cfg_bl_code != 2'd0) |=> !allow_rd);

    assert_rdap_closes_wr_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_rd_ap && (cfg_cl_int != '0 || cfg_cl_half)) |=> !allow_wr);

    assert_pre_act_open_R6: assert property (@(posedge clk) disable iff (rst)
        allow_pre && allow_act);

    assert_ref_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 4'd7 && !allow_ref) |=> violation);

    assert_lmr_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 4'd8 && !allow_lmr) |=> violation);

    assert_rd_flagged_R8: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !allow_rd && !same) |=> violation);

    assert_viol_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        violation |-> $past(cmd_valid));

    assert_bad_ap_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_ap && !allow_wr && !same && allow_rd) |=> allow_rd);

    assert_same_bank_free_R10: assert property (@(posedge clk) disable iff (rst)
        ((is_rd || is_wr || is_pa) && same) |=> !violation);
endmodule

bind ap_xbank_gate ap_xbank_gate_chk #(
    .BANK_W (BANK_W),
    .CL_W   (CL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cfg_bl_code (cfg_bl_code),
    .cfg_cl_int  (cfg_cl_int),
    .cfg_cl_half (cfg_cl_half),
    .allow_rd    (allow_rd),
    .allow_wr    (allow_wr),
    .allow_pre   (allow_pre),
    .allow_act   (allow_act),
    .allow_ref   (allow_ref),
    .allow_lmr   (allow_lmr),
    .violation   (violation)
);

// File: tb/tb_ap_xbank_gate.sv
module tb_ap_xbank_gate;
    localparam int BANK_W = 2;
    localparam int CL_W   = 3;
    localparam int TWTR_W = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              cmd_valid;
    logic [3:0]        cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [1:0]        cfg_bl_code;
    logic [CL_W-1:0]   cfg_cl_int;
    logic              cfg_cl_half;
    logic [TWTR_W-1:0] cfg_twtr;
    logic              all_banks_idle;
    logic allow_rd, allow_wr, allow_pre, allow_act, allow_ref, allow_lmr, violation;

    ap_xbank_gate #(.BANK_W(BANK_W), .CL_W(CL_W), .TWTR_W(TWTR_W)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cfg_bl_code(cfg_bl_code), .cfg_cl_int(cfg_cl_int),
        .cfg_cl_half(cfg_cl_half), .cfg_twtr(cfg_twtr), .all_banks_idle(all_banks_idle),
        .allow_rd(allow_rd), .allow_wr(allow_wr), .allow_pre(allow_pre),
        .allow_act(allow_act), .allow_ref(allow_ref), .allow_lmr(allow_lmr),
        .violation(violation)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ready[3];
    int m_bank = 0;
    bit m_src_wr = 1'b0;
    bit exp_viol = 1'b0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int tgt_of(input int op);
        if (op == 2 || op == 3) return 0;
        if (op == 4 || op == 5) return 1;
        if (op == 1 || op == 6) return 2;
        return -1;
    endfunction

    function automatic int exp_gap(input bit src_wr, input int tgt);
        int hb = 1 << int'(cfg_bl_code);
        int clu = int'(cfg_cl_int) + (cfg_cl_half ? 1 : 0);
        if (tgt == 0) return src_wr ? (1 + hb + int'(cfg_twtr)) : hb;
        if (tgt == 1) return src_wr ? hb : (clu + hb);
        return 1;
    endfunction

    // Called at a falling edge; issues one cycle of stimulus.
    task automatic step(input bit vld, input int op, input int bank);
        int t;
        bit bad;
        cmd_valid = vld;
        cmd_op    = 4'(op);
        cmd_bank  = BANK_W'(bank);
        #1;
        chk(m_src_wr ? "R2" : "R4", "allow_rd", int'(allow_rd), int'(cyc >= ready[0]));
        chk(m_src_wr ? "R3" : "R5", "allow_wr", int'(allow_wr), int'(cyc >= ready[1]));
        chk("R6", "allow_pre", int'(allow_pre), int'(cyc >= ready[2]));
        chk("R6", "allow_act", int'(allow_act), int'(cyc >= ready[2]));
        chk("R7", "allow_ref", int'(allow_ref), int'(all_banks_idle));
        chk("R7", "allow_lmr", int'(allow_lmr), int'(all_banks_idle));
        chk("R8", "violation", int'(violation), int'(exp_viol));
        t = tgt_of(op);
        bad = 1'b0;
        if (vld) begin
            if (op == 7 || op == 8) bad = !all_banks_idle;
            else if (t >= 0) bad = (bank != m_bank) && (cyc < ready[t]);
        end
        if (vld && (op == 3 || op == 5) && !bad) begin
            m_src_wr = (op == 5);
            m_bank = bank;
            for (int k = 0; k < 3; k++) ready[k] = cyc + exp_gap(m_src_wr, k);
        end
        exp_viol = bad;
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    function automatic bit flag_of(input int tgt);
        if (tgt == 0) return allow_rd;
        if (tgt == 1) return allow_wr;
        return allow_pre;
    endfunction

    // Issue an auto-precharge access, then count cycles until the flag opens.
    task automatic measure(input string req, input int op, input int tgt,
                           input int want, input bit perturb);
        int n;
        step(1'b1, op, 0);
        if (perturb) begin
            cfg_twtr = '0;
            cfg_bl_code = 2'd0;
        end
        n = 1;
        while (!flag_of(tgt) && n < 64) begin
            step(1'b0, 0, 0);
            n++;
        end
        chk(req, "window length", n, want);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) ready[k] = 0;
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_op = '0; cmd_bank = '0;
        cfg_bl_code = 2'd1; cfg_cl_int = 3'd2; cfg_cl_half = 1'b0;
        cfg_twtr = 4'd2; all_banks_idle = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "reset allow_rd", int'(allow_rd), 1);
        chk("R1", "reset allow_wr", int'(allow_wr), 1);
        chk("R1", "reset allow_act", int'(allow_act), 1);
        chk("R1", "reset violation", int'(violation), 0);

        // R2: BL/2=2, tWTR=2 -> 5
        measure("R2", 5, 0, 5, 1'b0);
        // R3: BL/2=4 -> 4
        cfg_bl_code = 2'd2; measure("R3", 5, 1, 4, 1'b0);
        // R4: BL/2=1 -> 1
        cfg_bl_code = 2'd0; measure("R4", 3, 0, 1, 1'b0);
        // R5: CL 2.5 rounds to 3, BL/2=2 -> 5
        cfg_bl_code = 2'd1; cfg_cl_half = 1'b1; measure("R5", 3, 1, 5, 1'b0);
        // R11: code 3 gives BL/2=8
        cfg_bl_code = 2'd3; measure("R11", 3, 0, 8, 1'b0);
        // R11: config change after acceptance: BL/2=2, tWTR=3 -> 6
        cfg_bl_code = 2'd1; cfg_twtr = 4'd3; measure("R11", 5, 0, 6, 1'b1);

        // R8/R9: rejected auto-precharge access to another bank
        cfg_bl_code = 2'd3; cfg_cl_half = 1'b0; cfg_twtr = 4'd1;
        step(1'b1, 3, 0);
        step(1'b1, 5, 1);
        step(1'b1, 2, 2);
        // R10: same bank during a closed window
        step(1'b1, 4, 0);
        step(1'b1, 5, 0);
        step(1'b1, 2, 0);
        // R6: precharge/activate right after
        step(1'b1, 6, 3);
        step(1'b1, 1, 2);
        // R7: refresh and mode load while busy
        all_banks_idle = 1'b0;
        step(1'b1, 7, 1);
        step(1'b1, 8, 2);
        all_banks_idle = 1'b1;
        step(1'b1, 7, 1);
        repeat (20) step(1'b0, 0, 0);
        chk("R9", "window after rejected access", int'(allow_rd), 1);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            int op;
            if (r < 12) op = 3;
            else if (r < 24) op = 5;
            else if (r < 40) op = 2;
            else if (r < 56) op = 4;
            else if (r < 64) op = 1;
            else if (r < 72) op = 6;
            else if (r < 76) op = 7;
            else if (r < 79) op = 8;
            else if (r < 82) op = int'($urandom_range(9, 15));
            else op = 0;
            if ($urandom_range(0, 15) == 0) begin
                cfg_bl_code = 2'($urandom_range(0, 3));
                cfg_cl_int  = 3'($urandom_range(1, 6));
                cfg_cl_half = 1'($urandom_range(0, 1));
                cfg_twtr    = 4'($urandom_range(0, 15));
            end
            all_banks_idle = ($urandom_range(0, 3) != 0);
            step(($urandom_range(0, 7) != 0), op, int'($urandom_range(0, 3)));
        end
        step(1'b0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule